// File: doc/BRIEF.md
# Adaptive Redundancy Mode Controller

This block picks how much redundancy a bank of four identical reconfigurable compute regions should run with, based on a measured single-event upset rate. It turns the chosen level into a region layout: one region alone, a self-checking pair, or a triple with a majority vote. Regions that the layout does not need are switched off so that they draw no power. The region results are then voted or compared to give one 32-bit answer. When a mismatch is seen, an error flag is raised and the region or regions to blame are marked for configuration scrubbing.

A hybrid policy can be selected. Under it, a task that carries its own algorithm-based fault tolerance runs in a single region. A task without such protection gets a pair or a triple, chosen by the upset rate. Layout changes are held back while a task is busy in the regions, so a result is never split across two layouts. The upset-rate measurement and the reconfiguration are done elsewhere.

Top module: `redund_mode_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, mode_o is 0 (low), region_en is 4'b0001, and out_valid, out_err and scrub_req are all 0.
- R2: With hybrid_sel low, mode_o follows upset_rate, an unsigned number with 4 fractional bits. Below 32 (2.0 per day) the mode is 0 (low). From 32 up to 127 the mode is 1 (medium). At 128 (8.0 per day) and above the mode is 2 (high).
- R3: With hybrid_sel high, mode_o is 3. When task_abft is 1 the layout is a single region. When task_abft is 0 the layout is a pair if upset_rate is below 128, and a triple otherwise.
- R4: region_en is 4'b0001 for a single region, 4'b0011 for a pair and 4'b0111 for a triple. Region 3 is never enabled.
- R5: A change of mode or layout is taken at a rising edge only when task_busy is low, and it shows on the ports after that edge. While task_busy is high, mode_o and region_en do not change.
- R6: If a layout change is taken at the same edge where res_valid is high, the result is dropped, and out_valid is 0 in the following cycle.
- R7: In a single-region layout, out_data equals region 0's result and out_err is 0.
- R8: In a pair layout, out_data equals region 0's result. If regions 0 and 1 differ, out_err is 1 and scrub_req is 4'b0011. Otherwise both are 0.
- R9: In a triple layout, out_data is the bitwise majority of regions 0, 1 and 2. When exactly one region disagrees with the other two, out_err is 1 and scrub_req has only that region's bit set (bit i for region i). When all three agree, out_err and scrub_req are 0.
- R10: In a triple layout where all three results differ, out_err is 1 and scrub_req is 4'b0111.
- R11: A result offered with res_valid at a rising edge appears one cycle later with out_valid high for one cycle. Whenever out_valid is 0, out_err and scrub_req are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upset_rate | input | 12 | Measured upset rate per day, unsigned, 4 fractional bits |
| hybrid_sel | input | 1 | Select the hybrid policy |
| task_abft | input | 1 | Current task has algorithm-based fault tolerance |
| task_busy | input | 1 | A task is in progress in the regions; layout changes wait |
| res_valid | input | 1 | Region results are valid this cycle |
| region_res | input | 96 | Results of regions 0..2, 32 bits each, region 0 in the low bits |
| mode_o | output | 2 | Current mode: 0 low, 1 medium, 2 high, 3 hybrid |
| region_en | output | 4 | Per-region enable; a low bit powers the region down |
| out_valid | output | 1 | Voted result is valid |
| out_data | output | 32 | Voted or compared result |
| out_err | output | 1 | Mismatch detected on this result |
| scrub_req | output | 4 | Per-region scrub request, valid with out_valid |

## Verification
The hardest case to reach from the ports is a layout change taken at the same edge as a valid result. It needs the policy inputs to move while task_busy is low and res_valid is high together. The bench drives this on purpose after several busy-held cycles, and also checks that a rate change during busy only takes effect once busy drops. The triple-vote cases where all three regions differ, or where one region differs, are reached by applying independent random bit masks to each region's copy of a base word. Random upset rates are drawn close to the two thresholds so that the limits at 31/32 and 127/128 are hit often.

// File: rtl/rmc_pkg.sv
`timescale 1ns/1ps
package rmc_pkg;
  localparam int NREG = 4;

  typedef enum logic [1:0] {
    MODE_LOW  = 2'd0,
    MODE_MED  = 2'd1,
    MODE_HIGH = 2'd2,
    MODE_HYB  = 2'd3
  } rmode_e;

  typedef enum logic [1:0] {
    LAY_SINGLE = 2'd0,
    LAY_PAIR   = 2'd1,
    LAY_TRIPLE = 2'd2
  } layout_e;

  // Region power/enable pattern for a layout; the spare region stays off.
  function automatic logic [NREG-1:0] layout_enables(layout_e lay);
    case (lay)
      LAY_PAIR:   return 4'b0011;
      LAY_TRIPLE: return 4'b0111;
      default:    return 4'b0001;
    endcase
  endfunction
endpackage

// File: rtl/rmc_policy.sv
`timescale 1ns/1ps
module rmc_policy
  import rmc_pkg::*;
#(
  parameter int RATE_W = 12,
  parameter int FRAC_W = 4
) (
  input  logic [RATE_W-1:0] rate,
  input  logic              hybrid_sel,
  input  logic              task_abft,
  output rmode_e            mode_want,
  output layout_e           lay_want
);
  localparam int unsigned LOW_TH_I  = 2 << FRAC_W;
  localparam int unsigned HIGH_TH_I = 8 << FRAC_W;
  localparam logic [RATE_W-1:0] LOW_TH  = LOW_TH_I[RATE_W-1:0];
  localparam logic [RATE_W-1:0] HIGH_TH = HIGH_TH_I[RATE_W-1:0];

  logic above_low, above_high;
  assign above_low  = (rate >= LOW_TH);
  assign above_high = (rate >= HIGH_TH);

  always_comb begin
    if (hybrid_sel) begin
      mode_want = MODE_HYB;
      if (task_abft)       lay_want = LAY_SINGLE;
      else if (above_high) lay_want = LAY_TRIPLE;
      else                 lay_want = LAY_PAIR;
    end else if (above_high) begin
      mode_want = MODE_HIGH;
      lay_want  = LAY_TRIPLE;
    end else if (above_low) begin
      mode_want = MODE_MED;
      lay_want  = LAY_PAIR;
    end else begin
      mode_want = MODE_LOW;
      lay_want  = LAY_SINGLE;
    end
  end
endmodule

// File: rtl/rmc_voter.sv
`timescale 1ns/1ps
module rmc_voter
  import rmc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  layout_e           lay,
  input  logic [DATA_W-1:0] r0,
  input  logic [DATA_W-1:0] r1,
  input  logic [DATA_W-1:0] r2,
  output logic [DATA_W-1:0] vote_data,
  output logic              vote_err,
  output logic [NREG-1:0]   vote_scrub
);
  logic [DATA_W-1:0] maj;
  logic eq01, eq02, eq12;

  genvar b;
  generate
    for (b = 0; b < DATA_W; b++) begin : g_maj
      assign maj[b] = (r0[b] & r1[b]) | (r0[b] & r2[b]) | (r1[b] & r2[b]);
    end
  endgenerate

  assign eq01 = (r0 == r1);
  assign eq02 = (r0 == r2);
  assign eq12 = (r1 == r2);

  always_comb begin
    vote_data  = r0;
    vote_scrub = '0;
    case (lay)
      LAY_PAIR: begin
        if (!eq01) vote_scrub = 4'b0011;
      end
      LAY_TRIPLE: begin
        vote_data = maj;
        if (eq01 && eq02)  vote_scrub = 4'b0000;
        else if (eq01)     vote_scrub = 4'b0100;
        else if (eq02)     vote_scrub = 4'b0010;
        else if (eq12)     vote_scrub = 4'b0001;
        else               vote_scrub = 4'b0111;
      end
      default: vote_scrub = '0;
    endcase
    vote_err = |vote_scrub;
  end
endmodule

// File: rtl/redund_mode_ctrl.sv
`timescale 1ns/1ps
module redund_mode_ctrl
  import rmc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int RATE_W = 12,
  parameter int FRAC_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [RATE_W-1:0]   upset_rate,
  input  logic                hybrid_sel,
  input  logic                task_abft,
  input  logic                task_busy,
  input  logic                res_valid,
  input  logic [3*DATA_W-1:0] region_res,
  output logic [1:0]          mode_o,
  output logic [NREG-1:0]     region_en,
  output logic                out_valid,
  output logic [DATA_W-1:0]   out_data,
  output logic                out_err,
  output logic [NREG-1:0]     scrub_req
);
  localparam int NVOTE = 3;

  rmode_e  mode_q, mode_want;
  layout_e lay_q, lay_want;

  logic [DATA_W-1:0] lane [NVOTE];
  genvar g;
  generate
    for (g = 0; g < NVOTE; g++) begin : g_lane
      assign lane[g] = region_res[g*DATA_W +: DATA_W];
    end
  endgenerate

  rmc_policy #(.RATE_W(RATE_W), .FRAC_W(FRAC_W)) u_policy (
    .rate       (upset_rate),
    .hybrid_sel (hybrid_sel),
    .task_abft  (task_abft),
    .mode_want  (mode_want),
    .lay_want   (lay_want)
  );

  logic [DATA_W-1:0] vote_data;
  logic              vote_err;
  logic [NREG-1:0]   vote_scrub;

  rmc_voter #(.DATA_W(DATA_W)) u_voter (
    .lay        (lay_q),
    .r0         (lane[0]),
    .r1         (lane[1]),
    .r2         (lane[2]),
    .vote_data  (vote_data),
    .vote_err   (vote_err),
    .vote_scrub (vote_scrub)
  );

  // Named events used by the checker.
  logic mode_switch, capture_ok;
  assign mode_switch = ((mode_want != mode_q) || (lay_want != lay_q)) && !task_busy;
  assign capture_ok  = res_valid && !mode_switch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_LOW;
      lay_q  <= LAY_SINGLE;
    end else if (mode_switch) begin
      mode_q <= mode_want;
      lay_q  <= lay_want;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_err   <= 1'b0;
      scrub_req <= '0;
    end else begin
      out_valid <= capture_ok;
      if (capture_ok) begin
        out_data  <= vote_data;
        out_err   <= vote_err;
        scrub_req <= vote_scrub;
      end else begin
        out_err   <= 1'b0;
        scrub_req <= '0;
      end
    end
  end

  assign mode_o    = mode_q;
  assign region_en = layout_enables(lay_q);
endmodule

// File: rtl/rmc_chk.sv
`timescale 1ns/1ps
module rmc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       task_busy,
  input logic       mode_switch,
  input logic [1:0] mode_o,
  input logic [3:0] region_en,
  input logic       out_valid,
  input logic       out_err,
  input logic [3:0] scrub_req
);
  assert_enable_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (region_en == 4'b0001) || (region_en == 4'b0011) || (region_en == 4'b0111));

  assert_hold_while_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    task_busy |=> ($stable(mode_o) && $stable(region_en)));

  assert_drop_on_switch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_switch |=> !out_valid);

  assert_single_no_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && region_en == 4'b0001) |-> (!out_err && scrub_req == 4'b0000));

  assert_pair_scrub_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && region_en == 4'b0011) |-> (scrub_req == 4'b0000 || scrub_req == 4'b0011));

  assert_triple_scrub_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && region_en == 4'b0111 && out_err) |->
      ($countones(scrub_req) == 1 || scrub_req == 4'b0111));

  assert_quiet_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_err && scrub_req == 4'b0000));
endmodule

bind redund_mode_ctrl rmc_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .task_busy   (task_busy),
  .mode_switch (mode_switch),
  .mode_o      (mode_o),
  .region_en   (region_en),
  .out_valid   (out_valid),
  .out_err     (out_err),
  .scrub_req   (scrub_req)
);

// File: tb/redund_mode_ctrl_tb.sv
`timescale 1ns/1ps
module redund_mode_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] upset_rate = '0;
  logic        hybrid_sel = 1'b0;
  logic        task_abft = 1'b0;
  logic        task_busy = 1'b0;
  logic        res_valid = 1'b0;
  logic [95:0] region_res = '0;
  logic [1:0]  mode_o;
  logic [3:0]  region_en;
  logic        out_valid;
  logic [31:0] out_data;
  logic        out_err;
  logic [3:0]  scrub_req;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  redund_mode_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .upset_rate(upset_rate), .hybrid_sel(hybrid_sel),
    .task_abft(task_abft), .task_busy(task_busy), .res_valid(res_valid),
    .region_res(region_res), .mode_o(mode_o), .region_en(region_en),
    .out_valid(out_valid), .out_data(out_data), .out_err(out_err), .scrub_req(scrub_req)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected layout code: 0 single, 1 pair, 2 triple.
  function automatic int exp_lay(input int rate, input bit hyb, input bit abft);
    if (hyb) return abft ? 0 : (rate >= 128 ? 2 : 1);
    if (rate >= 128) return 2;
    if (rate >= 32) return 1;
    return 0;
  endfunction

  function automatic int exp_mode(input int rate, input bit hyb);
    if (hyb) return 3;
    if (rate >= 128) return 2;
    if (rate >= 32) return 1;
    return 0;
  endfunction

  function automatic logic [3:0] exp_en(input int lay);
    logic [3:0] e = '0;
    for (int i = 0; i <= lay; i++) e[i] = 1'b1;
    return e;
  endfunction

  function automatic logic [31:0] exp_major(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
    logic [31:0] m;
    for (int i = 0; i < 32; i++) begin
      int n = int'(a[i]) + int'(b[i]) + int'(c[i]);
      m[i] = (n >= 2);
    end
    return m;
  endfunction

  function automatic logic [3:0] exp_scrub(input int lay, input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
    logic [31:0] v [3];
    logic [3:0] s = '0;
    int agree;
    if (lay == 0) return 4'b0000;
    if (lay == 1) return (a != b) ? 4'b0011 : 4'b0000;
    v[0] = a; v[1] = b; v[2] = c;
    if (a == b && b == c) return 4'b0000;
    for (int i = 0; i < 3; i++) begin
      agree = 0;
      for (int j = 0; j < 3; j++) if (j != i && v[j] == v[i]) agree++;
      if (agree == 0) s[i] = 1'b1;
    end
    return s;
  endfunction

  int cur_lay = 0;

  task automatic set_policy(input int rate, input bit hyb, input bit abft, input string tag);
    upset_rate = 12'(rate); hybrid_sel = hyb; task_abft = abft;
    task_busy = 1'b0; res_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    cur_lay = exp_lay(rate, hyb, abft);
    check(mode_o == 2'(exp_mode(rate, hyb)), tag, 64'(mode_o), 64'(exp_mode(rate, hyb)));
    check(region_en == exp_en(cur_lay), {tag, "/R4"}, 64'(region_en), 64'(exp_en(cur_lay)));
  endtask

  task automatic vote(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c, input string tag);
    logic [31:0] ed;
    logic [3:0]  es;
    region_res = {c, b, a};
    res_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    res_valid = 1'b0;
    ed = (cur_lay == 2) ? exp_major(a, b, c) : a;
    es = exp_scrub(cur_lay, a, b, c);
    check(out_valid == 1'b1, {tag, "/R11 valid"}, 64'(out_valid), 64'd1);
    check(out_data == ed, {tag, " data"}, 64'(out_data), 64'(ed));
    check(scrub_req == es, {tag, " scrub"}, 64'(scrub_req), 64'(es));
    check(out_err == (es != 0), {tag, " err"}, 64'(out_err), 64'(es != 0));
    @(negedge clk);
    check(!out_valid && !out_err && scrub_req == 0, "R11 quiet after result",
          64'({out_valid, out_err, scrub_req}), 64'd0);
  endtask

  function automatic logic [31:0] corrupt(input logic [31:0] v);
    if ($urandom_range(0, 3) == 0) return v ^ ($urandom() | 32'd1);
    return v;
  endfunction

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(mode_o == 2'd0 && region_en == 4'b0001, "R1 in reset", 64'({mode_o, region_en}), 64'h01);
    check(!out_valid && !out_err && scrub_req == 0, "R1 outputs in reset", 64'({out_valid, out_err, scrub_req}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(mode_o == 2'd0 && region_en == 4'b0001 && !out_valid, "R1 after reset",
          64'({out_valid, mode_o, region_en}), 64'h01);

    // Threshold edges (R2)
    set_policy(31, 0, 0, "R2 rate 31");
    set_policy(32, 0, 0, "R2 rate 32");
    set_policy(127, 0, 0, "R2 rate 127");
    set_policy(128, 0, 0, "R2 rate 128");
    set_policy(4095, 0, 0, "R2 rate max");
    set_policy(0, 0, 0, "R2 rate 0");

    // Single region (R7)
    vote(32'h1234_5678, 32'hDEAD_BEEF, 32'h0, "R7 single");

    // Pair (R8)
    set_policy(64, 0, 0, "R2 medium");
    vote(32'hCAFE_0001, 32'hCAFE_0001, 32'h5, "R8 pair agree");
    vote(32'hCAFE_0001, 32'hCAFE_0003, 32'h5, "R8 pair mismatch");

    // Triple (R9, R10)
    set_policy(200, 0, 0, "R2 high");
    vote(32'hAAAA_0000, 32'hAAAA_0000, 32'hAAAA_0000, "R9 all agree");
    vote(32'hF0F0_F0F0, 32'hF0F0_F0F0, 32'h0F0F_0F0F, "R9 region2 bad");
    vote(32'h1111_1111, 32'h2222_2222, 32'h1111_1111, "R9 region1 bad");
    vote(32'h0000_00FF, 32'h0000_FF00, 32'h0000_FF00, "R9 region0 bad");
    vote(32'h0000_0001, 32'h0000_0002, 32'h0000_0004, "R10 all differ");

    // Hybrid (R3)
    set_policy(200, 1, 1, "R3 hybrid abft");
    vote(32'h7, 32'h9, 32'hB, "R3/R7 hybrid single");
    set_policy(200, 1, 0, "R3 hybrid high no abft");
    set_policy(100, 1, 0, "R3 hybrid low no abft");
    vote(32'h55, 32'h54, 32'h0, "R3/R8 hybrid pair");

    // Busy holds the layout (R5)
    task_busy = 1'b1; upset_rate = 12'd300; hybrid_sel = 1'b0;
    repeat (3) @(negedge clk);
    check(mode_o == 2'd3 && region_en == 4'b0011, "R5 held while busy", 64'({mode_o, region_en}), 64'h33);
    task_busy = 1'b0;
    @(negedge clk);
    check(mode_o == 2'd2 && region_en == 4'b0111, "R5 taken after busy", 64'({mode_o, region_en}), 64'h27);
    cur_lay = 2;

    // Switch together with a valid result (R6)
    upset_rate = 12'd10; region_res = {32'h3, 32'h2, 32'h1}; res_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    res_valid = 1'b0;
    check(!out_valid, "R6 result dropped on switch", 64'(out_valid), 64'd0);
    check(mode_o == 2'd0 && region_en == 4'b0001, "R6 new mode", 64'({mode_o, region_en}), 64'h01);
    cur_lay = 0;

    // Random mix (R2, R3, R4, R7-R10)
    for (int it = 0; it < 150; it++) begin
      int r;
      bit h, ab;
      logic [31:0] base;
      case ($urandom_range(0, 3))
        0: r = $urandom_range(24, 40);
        1: r = $urandom_range(120, 136);
        2: r = $urandom_range(0, 4095);
        default: r = $urandom_range(0, 160);
      endcase
      h = ($urandom_range(0, 3) == 0);
      ab = $urandom_range(0, 1);
      set_policy(r, h, ab, "R2/R3 random policy");
      base = $urandom();
      vote(corrupt(base), corrupt(base), corrupt(base), "R9/R10 random vote");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #4_000_000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule